// File: doc/BRIEF.md
# Single-Link 18-bit Pixel Lane Packer

This block sits between a pixel pipeline and a 7:1 serializer for a single-link, 18-bit flat-panel link. Each pixel clock it accepts one pixel (6-bit red, green and blue, a data-enable flag, horizontal sync and vertical sync). It spreads those 21 bits over three 7-bit data lane words and also drives a 7-bit clock lane word. The serializer shifts each lane word out bit 6 first, so bit 6 of every lane word is the first-sent slot and bit 0 is the last.

The slot assignment is fixed and not contiguous. Lane 0 carries the least significant green bit followed by all of red. Lane 1 mixes the middle green bits with two blue bits. Lane 2 carries the enable flag, the upper blue bits and both syncs. A larger colour code means a brighter colour: all zeros is black and all ones is full intensity. During blanking (enable low) every colour slot is sent as zero, while the sync slots still follow their inputs.

All four lane words are loaded on the same clock edge, so the words presented together always belong to one pixel. The output shows a pixel one cycle after it is presented. The clock lane word is the constant framing pattern 1100011. The receiver uses it to find word boundaries.

Top module: `lvds18_packer`

## Requirements
- R1: Lane 0 word = {G0, R5, R4, R3, R2, R1, R0} from bit 6 down to bit 0, when enable is high.
- R2: Lane 1 word = {B1, G4, G3, G2, G1, B0, G5} from bit 6 down to bit 0, when enable is high.
- R3: Lane 2 word = {DE, B5, B4, B3, B2, VSYNC, HSYNC} from bit 6 down to bit 0. Bits 1 and 0 always carry vertical and horizontal sync.
- R4: When enable is low, lane 0 and lane 1 are all zeros and lane 2 bits 6..2 are zeros, whatever the colour inputs are. The sync slots still pass through.
- R5: The clock lane word is 7'b1100011 in every cycle, during and after reset.
- R6: A synchronous reset, sampled high at a clock edge, sets all three data lane words to zero. This holds regardless of the pixel inputs present at that edge.
- R7: A pixel presented before clock edge N appears on all four lane words together after edge N and stays there until edge N+1. The latency is exactly one cycle, and consecutive pixels are never mixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| de_i | input | 1 | Data enable (active video) |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| red_i | input | 6 | Red code, larger is brighter |
| grn_i | input | 6 | Green code, larger is brighter |
| blu_i | input | 6 | Blue code, larger is brighter |
| lane0_o | output | 7 | Data lane 0 word, bit 6 sent first |
| lane1_o | output | 7 | Data lane 1 word, bit 6 sent first |
| lane2_o | output | 7 | Data lane 2 word, bit 6 sent first |
| clk_lane_o | output | 7 | Clock lane word, bit 6 sent first |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is reset and a live pixel. The bench holds reset high while driving a full-white, enabled pixel with both syncs high. The data lanes must read all zeros and the clock lane must still show its pattern.

The second pair is blanking and sync. The bench drops enable while the syncs toggle and the colour inputs stay at full scale. It then checks that only the two sync slots of lane 2 carry ones. A pixel sequence driven back to back confirms that each cycle's lane words match only the previous cycle's pixel.

// File: rtl/lvds18_packer.sv
module lvds18_packer #(
  parameter logic [6:0] CLK_WORD = 7'b1100011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       de_i,
  input  logic       hs_i,
  input  logic       vs_i,
  input  logic [5:0] red_i,
  input  logic [5:0] grn_i,
  input  logic [5:0] blu_i,
  output logic [6:0] lane0_o,
  output logic [6:0] lane1_o,
  output logic [6:0] lane2_o,
  output logic [6:0] clk_lane_o
);

  logic [5:0] r_g, g_g, b_g;
  logic [6:0] nxt0, nxt1, nxt2;

  // blanking gates every colour slot
  assign r_g = de_i ? red_i : '0;
  assign g_g = de_i ? grn_i : '0;
  assign b_g = de_i ? blu_i : '0;

  // bit 6 is the first slot on the wire
  assign nxt0 = {g_g[0], r_g[5], r_g[4], r_g[3], r_g[2], r_g[1], r_g[0]};
  assign nxt1 = {b_g[1], g_g[4], g_g[3], g_g[2], g_g[1], b_g[0], g_g[5]};
  assign nxt2 = {de_i,   b_g[5], b_g[4], b_g[3], b_g[2], vs_i,   hs_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      lane0_o    <= '0;
      lane1_o    <= '0;
      lane2_o    <= '0;
      clk_lane_o <= CLK_WORD;
    end else begin
      lane0_o    <= nxt0;
      lane1_o    <= nxt1;
      lane2_o    <= nxt2;
      clk_lane_o <= CLK_WORD;
    end
  end

  p_lane0_map_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(de_i) |-> lane0_o == {$past(grn_i[0]), $past(red_i)});

  p_lane1_map_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(de_i) |->
      lane1_o == {$past(blu_i[1]), $past(grn_i[4:1]), $past(blu_i[0]), $past(grn_i[5])});

  p_sync_slots_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> lane2_o[1:0] == {$past(vs_i), $past(hs_i)});

  p_blank_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(!de_i) |-> lane0_o == 7'd0 && lane1_o == 7'd0 && lane2_o[6:2] == 5'd0);

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> lane0_o == 7'd0 && lane1_o == 7'd0 && lane2_o == 7'd0);

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> lane2_o[6] == $past(de_i) && lane2_o[5:2] == ($past(de_i) ? $past(blu_i[5:2]) : 4'd0));

endmodule

// File: tb/test_lvds18_packer.sv
module test_lvds18_packer;
  logic       clk = 1'b0;
  logic       rst;
  logic       de_i, hs_i, vs_i;
  logic [5:0] red_i, grn_i, blu_i;
  logic [6:0] lane0_o, lane1_o, lane2_o, clk_lane_o;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] CLK_PAT = 7'b1100011;
  localparam int NVEC = 9;
  // stimulus {de, vs, hs, red, grn, blu}
  localparam logic [20:0] STIM [NVEC] = '{
    {3'b100, 6'h3F, 6'h00, 6'h00},
    {3'b100, 6'h00, 6'h3F, 6'h00},
    {3'b100, 6'h00, 6'h00, 6'h3F},
    {3'b111, 6'h3F, 6'h3F, 6'h3F},
    {3'b010, 6'h3F, 6'h3F, 6'h3F},
    {3'b101, 6'b100001, 6'b000001, 6'b100000},
    {3'b100, 6'h00, 6'b100000, 6'b000011},
    {3'b100, 6'h00, 6'b011110, 6'h00},
    {3'b001, 6'h15, 6'h2A, 6'h15}
  };
  // expected {lane2, lane1, lane0}
  localparam logic [20:0] EXPV [NVEC] = '{
    {7'b1000000, 7'b0000000, 7'b0111111},
    {7'b1000000, 7'b0111101, 7'b1000000},
    {7'b1111100, 7'b1000010, 7'b0000000},
    {7'b1111111, 7'b1111111, 7'b1111111},
    {7'b0000010, 7'b0000000, 7'b0000000},
    {7'b1100001, 7'b0000000, 7'b1100001},
    {7'b1000000, 7'b1000011, 7'b0000000},
    {7'b1000000, 7'b0111100, 7'b0000000},
    {7'b0000001, 7'b0000000, 7'b0000000}
  };

  lvds18_packer i_lvds18_packer (
    .clk(clk), .rst(rst), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .lane0_o(lane0_o), .lane1_o(lane1_o), .lane2_o(lane2_o), .clk_lane_o(clk_lane_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [20:0] v);
    @(negedge clk);
    {de_i, vs_i, hs_i, red_i, grn_i, blu_i} = v;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    {de_i, vs_i, hs_i, red_i, grn_i, blu_i} = '1;
    repeat (3) @(posedge clk);
    #1;
    // R6 reset wins over a live full-white pixel; R5 pattern during reset
    chk("R6 lane0 in reset", lane0_o, 7'd0);
    chk("R6 lane1 in reset", lane1_o, 7'd0);
    chk("R6 lane2 in reset", lane2_o, 7'd0);
    chk("R5 clock lane in reset", clk_lane_o, CLK_PAT);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R4 R7: back-to-back vectors, each checked one edge later
    for (int k = 0; k < NVEC; k++) begin
      drive(STIM[k]);
      @(posedge clk);
      #1;
      chk($sformatf("R1 lane0 vec%0d", k), lane0_o, EXPV[k][6:0]);
      chk($sformatf("R2 lane1 vec%0d", k), lane1_o, EXPV[k][13:7]);
      chk($sformatf("R3 lane2 vec%0d", k), lane2_o, EXPV[k][20:14]);
      chk($sformatf("R5 clock lane vec%0d", k), clk_lane_o, CLK_PAT);
    end

    // R7: output holds pixel until the next edge, not the newly driven one
    drive({3'b100, 6'h3F, 6'h00, 6'h00});
    @(posedge clk);
    #1;
    @(negedge clk);
    {de_i, vs_i, hs_i, red_i, grn_i, blu_i} = {3'b111, 6'h00, 6'h00, 6'h3F};
    #1;
    chk("R7 lane0 held before edge", lane0_o, 7'b0111111);
    chk("R7 lane2 held before edge", lane2_o, 7'b1000000);
    @(posedge clk);
    #1;
    chk("R7 lane0 after edge", lane0_o, 7'b0000000);
    chk("R7 lane2 after edge", lane2_o, 7'b1111111);
    chk("R7 lane1 after edge", lane1_o, 7'b1000010);

    // R4: blanking with syncs toggling and colours at full scale
    drive({3'b001, 6'h3F, 6'h3F, 6'h3F});
    @(posedge clk); #1;
    chk("R4 blank hs lane2", lane2_o, 7'b0000001);
    chk("R4 blank lane0", lane0_o, 7'd0);
    drive({3'b011, 6'h3F, 6'h3F, 6'h3F});
    @(posedge clk); #1;
    chk("R4 blank both syncs lane2", lane2_o, 7'b0000011);
    chk("R4 blank lane1", lane1_o, 7'd0);

    // R6 mid-stream reset, then recovery
    @(negedge clk);
    rst = 1'b1;
    {de_i, vs_i, hs_i, red_i, grn_i, blu_i} = '1;
    @(posedge clk); #1;
    chk("R6 mid reset lane0", lane0_o, 7'd0);
    chk("R6 mid reset lane2", lane2_o, 7'd0);
    chk("R5 clock lane mid reset", clk_lane_o, CLK_PAT);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R7 first pixel after reset lane1", lane1_o, 7'b1111111);
    chk("R5 clock lane after reset", clk_lane_o, CLK_PAT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule